// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Clock-Domain Handshake

This block joins two controllers that run on unrelated clocks. The initiator lives in clock domain A. It accepts a start request together with a data word, holds that word, and runs one full return-to-zero request/acknowledge exchange with the responder. The responder lives in clock domain B. It answers the request with an acknowledge and hands the received word to its own domain as a single-cycle event.

Each control line passes through a chain of flip-flops clocked by the receiving domain before any logic there uses it. The data word itself is not synchronized. The protocol keeps it frozen while the responder samples it. A transfer ends when the initiator has seen the acknowledge fall again. At that point the initiator gives a one-cycle completion pulse and is ready for the next start.

Top module: `dual_clock_handshake`

## Requirements
- R1: While its reset is low, each side holds its outputs low: a_busy, a_done, b_event and the internal request and acknowledge lines are all 0.
- R2: A start (a_start = 1) sampled while a_busy = 0 is accepted on that clock-A edge. a_busy reads 1 from the next clock-A cycle, and the word on a_word is captured at that same edge.
- R3: Once raised, the request stays high until the synchronized acknowledge reads 1. The captured word does not change while a_busy = 1.
- R4: After the initiator sees the acknowledge high, it lowers the request in the next cycle. It does not begin a new request until the synchronized acknowledge has returned to 0.
- R5: The responder raises the acknowledge only after its synchronized request reads 1. In the same clock-B cycle that the acknowledge rises, b_event is 1 for exactly one cycle, and b_word carries the captured word.
- R6: The responder lowers the acknowledge only after its synchronized request reads 0.
- R7: A start that arrives while a_busy = 1 is ignored. It produces no extra b_event, and it does not alter the word in flight.
- R8: a_done pulses for exactly one clock-A cycle when the synchronized acknowledge returns to 0. In that cycle a_busy is already 0.
- R9: Each accepted word appears on b_word exactly once, and words appear in the order they were accepted, whatever the ratio of the two clock periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Initiator clock |
| rst_a_n | input | 1 | Initiator reset, active low |
| a_start | input | 1 | Request to begin a transfer |
| a_word | input | WORD_W | Word to transfer, sampled with an accepted start |
| a_busy | output | 1 | A transfer is in progress |
| a_done | output | 1 | One-cycle pulse at the end of a transfer |
| clk_b | input | 1 | Responder clock |
| rst_b_n | input | 1 | Responder reset, active low |
| b_event | output | 1 | One-cycle pulse: a word has arrived |
| b_word | output | WORD_W | Received word, valid from the b_event cycle on |

## Verification
Every cycle, the assertions check the local protocol rules of each side:
- the request is held until the acknowledge is seen, then released;
- no new request starts over a high acknowledge;
- the acknowledge follows the synchronized request in both directions;
- the word stays frozen while busy;
- the event and done pulses last one cycle.

Some properties span both clock domains and only the bench's scenarios can show them. These are:
- every one of the 256 possible words crosses exactly once and in order;
- starts issued mid-transfer leave no trace at the responder;
- the completion count equals the transfer count when the two clocks have unrelated periods.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        INI_IDLE    = 2'd0,
        INI_REQ     = 2'd1,
        INI_RELEASE = 2'd2
    } ini_state_e;

    typedef enum logic {
        RSP_WAIT = 1'b0,
        RSP_ACK  = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_chain
            always_comb chain_d = {chain_q[LAST-1:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[LAST];
endmodule

// File: rtl/hs_initiator.sv
module hs_initiator
    import hs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] start_word,
    input  logic         ack_sync,
    output logic         req,
    output logic [W-1:0] word,
    output logic         busy,
    output logic         done
);
    typedef struct packed {
        ini_state_e   state;
        logic         req;
        logic [W-1:0] word;
        logic         done;
    } ini_regs_t;

    ini_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            INI_IDLE: begin
                if (start) begin
                    r_d.state = INI_REQ;
                    r_d.req   = 1'b1;
                    r_d.word  = start_word;
                end
            end
            INI_REQ: begin
                if (ack_sync) begin
                    r_d.state = INI_RELEASE;
                    r_d.req   = 1'b0;
                end
            end
            INI_RELEASE: begin
                if (!ack_sync) begin
                    r_d.state = INI_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d.state = INI_IDLE;
                r_d.req   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= INI_IDLE;
            r_q.req   <= 1'b0;
            r_q.word  <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req  = r_q.req;
    assign word = r_q.word;
    assign busy = (r_q.state != INI_IDLE);
    assign done = r_q.done;
endmodule

// File: rtl/hs_responder.sv
module hs_responder
    import hs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_sync,
    input  logic [W-1:0] word_in,
    output logic         ack,
    output logic         event_p,
    output logic [W-1:0] word_out
);
    typedef struct packed {
        rsp_state_e   state;
        logic         ack;
        logic         evt;
        logic [W-1:0] word;
    } rsp_regs_t;

    rsp_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.evt = 1'b0;
        unique case (r_q.state)
            RSP_WAIT: begin
                if (req_sync) begin
                    r_d.state = RSP_ACK;
                    r_d.ack   = 1'b1;
                    r_d.evt   = 1'b1;
                    r_d.word  = word_in;
                end
            end
            RSP_ACK: begin
                if (!req_sync) begin
                    r_d.state = RSP_WAIT;
                    r_d.ack   = 1'b0;
                end
            end
            default: r_d.state = RSP_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= RSP_WAIT;
            r_q.ack   <= 1'b0;
            r_q.evt   <= 1'b0;
            r_q.word  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack      = r_q.ack;
    assign event_p  = r_q.evt;
    assign word_out = r_q.word;
endmodule

// File: rtl/dual_clock_handshake.sv
module dual_clock_handshake #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              a_start,
    input  logic [WORD_W-1:0] a_word,
    output logic              a_busy,
    output logic              a_done,
    input  logic              clk_b,
    input  logic              rst_b_n,
    output logic              b_event,
    output logic [WORD_W-1:0] b_word
);
    logic              req_line;
    logic              ack_line;
    logic              ack_at_a;
    logic              req_at_b;
    logic [WORD_W-1:0] held_word;

    hs_initiator #(.W(WORD_W)) u_ini (
        .clk        (clk_a),
        .rst_n      (rst_a_n),
        .start      (a_start),
        .start_word (a_word),
        .ack_sync   (ack_at_a),
        .req        (req_line),
        .word       (held_word),
        .busy       (a_busy),
        .done       (a_done)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk_a),
        .rst_n (rst_a_n),
        .d     (ack_line),
        .q     (ack_at_a)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk_b),
        .rst_n (rst_b_n),
        .d     (req_line),
        .q     (req_at_b)
    );

    hs_responder #(.W(WORD_W)) u_rsp (
        .clk      (clk_b),
        .rst_n    (rst_b_n),
        .req_sync (req_at_b),
        .word_in  (held_word),
        .ack      (ack_line),
        .event_p  (b_event),
        .word_out (b_word)
    );
endmodule

// File: rtl/hs_checker.sv
module hs_checker #(
    parameter int W = 8
) (
    input logic         clk_a,
    input logic         rst_a_n,
    input logic         clk_b,
    input logic         rst_b_n,
    input logic         a_start,
    input logic         a_busy,
    input logic         a_done,
    input logic         req_line,
    input logic         ack_at_a,
    input logic         ack_line,
    input logic         req_at_b,
    input logic         b_event,
    input logic [W-1:0] held_word
);
    always_comb begin
        if (!rst_a_n) AST_RESET_A: assert (!a_busy && !a_done && !req_line); // R1
        if (!rst_b_n) AST_RESET_B: assert (!b_event && !ack_line);           // R1
    end

    AST_START_TAKEN: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (a_start && !a_busy) |=> a_busy);                                    // R2
    AST_REQ_HOLD: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (req_line && !ack_at_a) |=> req_line);                               // R3
    AST_WORD_FROZEN: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        a_busy |=> $stable(held_word));                                      // R3
    AST_REQ_RELEASE: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (req_line && ack_at_a) |=> !req_line);                               // R4
    AST_NO_EARLY_REQ: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $rose(req_line) |-> !ack_at_a);                                      // R4
    AST_ACK_AFTER_REQ: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        $rose(ack_line) |-> $past(req_at_b));                                // R5
    AST_EVENT_ON_ACK: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        $rose(ack_line) |-> b_event);                                        // R5
    AST_EVENT_PULSE: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        b_event |=> !b_event);                                               // R5
    AST_ACK_DROP: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        $fell(ack_line) |-> !$past(req_at_b));                               // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (a_start && a_busy) |=> $stable(held_word));                         // R7
    AST_DONE_PULSE: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        a_done |=> !a_done);                                                 // R8
    AST_DONE_IDLE: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        a_done |-> !a_busy);                                                 // R8
endmodule

bind dual_clock_handshake hs_checker #(.W(WORD_W)) u_chk (
    .clk_a     (clk_a),
    .rst_a_n   (rst_a_n),
    .clk_b     (clk_b),
    .rst_b_n   (rst_b_n),
    .a_start   (a_start),
    .a_busy    (a_busy),
    .a_done    (a_done),
    .req_line  (req_line),
    .ack_at_a  (ack_at_a),
    .ack_line  (ack_line),
    .req_at_b  (req_at_b),
    .b_event   (b_event),
    .held_word (held_word)
);

// File: tb/sim_dual_clock_handshake.sv
`timescale 1ns/10ps
module sim_dual_clock_handshake;
    localparam int W     = 8;
    localparam int NWORD = 1 << W;

    logic         clk_a = 1'b0, clk_b = 1'b0;
    logic         rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic         a_start = 1'b0;
    logic [W-1:0] a_word = '0;
    logic         a_busy, a_done, b_event;
    logic [W-1:0] b_word;

    int vectors = 0, errors = 0;
    int recv_cnt = 0, done_cnt = 0;
    logic prev_evt = 1'b0;
    int seen [NWORD];

    always #5    clk_a = ~clk_a;
    always #3.65 clk_b = ~clk_b;

    dual_clock_handshake #(.WORD_W(W), .SYNC_STAGES(2)) u0 (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .a_start(a_start), .a_word(a_word),
        .a_busy(a_busy), .a_done(a_done),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .b_event(b_event), .b_word(b_word)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Responder-side monitor: R5, R7, R9
    always @(negedge clk_b) begin
        if (rst_b_n) begin
            if (b_event) begin
                check(!prev_evt, "R5 event width", 2, 1);
                check(b_word == W'(recv_cnt), "R9 R7 word order", int'(b_word), recv_cnt % NWORD);
                seen[b_word]++;
                recv_cnt++;
            end
            prev_evt <= b_event;
        end
    end

    always @(negedge clk_a) if (rst_a_n && a_done) done_cnt++;

    initial begin
        for (int i = 0; i < NWORD; i++) seen[i] = 0;
        repeat (4) @(negedge clk_a);
        check(a_busy == 1'b0, "R1 busy in reset", int'(a_busy), 0);
        check(a_done == 1'b0, "R1 done in reset", int'(a_done), 0);
        check(b_event == 1'b0, "R1 event in reset", int'(b_event), 0);
        rst_a_n = 1'b1;
        @(negedge clk_b);
        rst_b_n = 1'b1;
        repeat (3) @(negedge clk_a);
        check(a_busy == 1'b0, "R1 idle after reset", int'(a_busy), 0);

        for (int i = 0; i < NWORD; i++) begin
            int cyc;
            a_start = 1'b1;
            a_word  = W'(i);
            @(negedge clk_a);
            a_start = 1'b0;
            a_word  = ~W'(i);
            check(a_busy == 1'b1, "R2 busy after start", int'(a_busy), 1);
            if (i % 2 == 1) begin
                @(negedge clk_a);
                a_start = 1'b1;   // R7 stray start while busy
                @(negedge clk_a);
                a_start = 1'b0;
                check(a_busy == 1'b1, "R7 still busy", int'(a_busy), 1);
            end
            cyc = 0;
            while (!a_done && cyc < 200) begin
                @(negedge clk_a);
                cyc++;
            end
            check(a_done == 1'b1, "R4 R6 transfer completes", int'(a_done), 1);
            check(a_busy == 1'b0, "R8 idle with done", int'(a_busy), 0);
            @(negedge clk_a);
            check(a_done == 1'b0, "R8 done width", int'(a_done), 0);
            repeat (i % 3) @(negedge clk_a);
        end

        repeat (20) @(negedge clk_a);
        check(recv_cnt == NWORD, "R9 R7 event count", recv_cnt, NWORD);
        check(done_cnt == NWORD, "R8 done count", done_cnt, NWORD);
        for (int i = 0; i < NWORD; i++)
            if (seen[i] != 1) check(1'b0, "R9 exactly once", seen[i], 1);
        vectors++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_a);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule